// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for a single video output. Free-running pixel and line counters sweep the frame. From their values the block decodes a display-enable window and horizontal and vertical sync pulses, and each sync pulse has its own programmable polarity. Alongside the timing, the block keeps a scanout byte address for the current line. Downstream fetch logic reads that address to locate the pixels of the line it is about to show.

Configuration goes through a write-only register file of eight 32-bit words. Horizontal sizes are counted in characters of 8 pixels. Totals, display extents and the vertical sync start are stored as the count minus one. The start of the horizontal sync can be placed on any single pixel.

Every register except the enable bit is buffered in a shadow copy, and the values in use are refreshed at defined points in the frame. Timing, pixel format and pitch are refreshed at the end of the frame. The pan position and the frame base are refreshed when vertical blanking begins. Because of this buffering, software can pan the image without producing a torn frame.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset, h_cnt_o and v_cnt_o are 0, and de_o, hsync_o, vsync_o and line_addr_o are all 0.
- R2: Register 0 is the control word. Bit 0 enables the block, and a change to it acts from the next cycle. Bits [9:8] give a code n, and the pixel size is 2^n bytes. Bits [11:10] have no effect. While the block is disabled, both counters are held at 0, de_o is 0, and each sync output sits at its inactive level. The first cycle after enabling shows pixel 0 of line 0.
- R3: Register 1 holds the horizontal total in characters minus one in [8:0], and the display width in characters minus one in [24:16]. h_cnt_o advances by one each cycle from 0 up to 8*(total+1)-1 and then returns to 0.
- R4: Register 3 holds the vertical total minus one in [11:0], and the display height minus one in [27:16]. v_cnt_o advances whenever h_cnt_o wraps. It returns to 0 after the line equal to the total field.
- R5: de_o is 1 exactly when h_cnt_o <= 8*width_field+7 and v_cnt_o <= height_field.
- R6: Register 2 holds the hsync start pixel in [11:0], made of a character in [11:3] and a pixel within that character in [2:0]. The width in characters is in [21:16], and bit 23 selects active-low. hsync_o is active for the h_cnt_o values from start up to (but not including) start+8*width.
- R7: Register 4 holds the vsync start line minus one in [11:0], the width in lines in [20:16], and active-low in bit 23. vsync_o is active on the lines L where start+1 <= L < start+1+width.
- R8: Register 5 holds the line pitch in 8-pixel units in [9:0]. The duplicate copy in [25:16] is ignored. The pitch in bytes equals pitch*8*2^n.
- R9: Register 6 holds pan x in [15:0] and pan y in [31:16], and register 7 holds the frame base. On line 0, line_addr_o = y*pitch_bytes + (x with bits [2:0] cleared)*2^n + base. The address stays constant within a line and grows by pitch_bytes after each displayed line.
- R10: Writes to registers 6 and 7 take effect when the last displayed line ends. A write made earlier in the frame leaves that frame's addresses unchanged.
- R11: Writes to registers 1 to 5, and to bits [9:8] of register 0, take effect when the last line of the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index |
| wr_data_i | input | 32 | Write data |
| h_cnt_o | output | 12 | Pixel position in line |
| v_cnt_o | output | 12 | Line position in frame |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| line_addr_o | output | 32 | Scanout byte address of current line |

## Verification
The hardest behaviour to reach is a register write that lands between the two copy points. One example is a pan write made after vertical blanking has begun but before the frame ends. Another is a timing write made in the middle of the active display. In both cases the new value must stay hidden until its own boundary arrives. To reach these cases, the stimulus issues its register writes while the block is running, at randomly chosen cycles. A cycle-accurate reference model in the bench keeps separate shadow and in-use copies and checks every output on every cycle. Directed cases add a disable in the middle of a frame, writes to the ignored control bits, and single-pixel hsync starts.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int DW    = 32;
  localparam int RAW   = 3;
  localparam int AW    = 32;
  localparam int HCHW  = 9;
  localparam int HCW   = HCHW + 3;
  localparam int VLW   = 12;
  localparam int HSWW  = 6;
  localparam int VSWW  = 5;
  localparam int PW    = 10;
  localparam int PANW  = 16;
  localparam int BPPW  = 2;

  localparam logic [RAW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [RAW-1:0] ADR_HTD   = 3'd1;
  localparam logic [RAW-1:0] ADR_HSYNC = 3'd2;
  localparam logic [RAW-1:0] ADR_VTD   = 3'd3;
  localparam logic [RAW-1:0] ADR_VSYNC = 3'd4;
  localparam logic [RAW-1:0] ADR_PITCH = 3'd5;
  localparam logic [RAW-1:0] ADR_PAN   = 3'd6;
  localparam logic [RAW-1:0] ADR_BASE  = 3'd7;

  localparam int POL_BIT = 23;
  localparam int HI_LSB  = 16;
  localparam int FMT_LSB = 8;

  typedef struct packed {
    logic [BPPW-1:0] bpp_sh;
    logic [HCHW-1:0] htot;
    logic [HCHW-1:0] hdisp;
    logic [HCW-1:0]  hs_start;
    logic [HSWW-1:0] hs_wid;
    logic            hs_low;
    logic [VLW-1:0]  vtot;
    logic [VLW-1:0]  vdisp;
    logic [VLW-1:0]  vs_start;
    logic [VSWW-1:0] vs_wid;
    logic            vs_low;
    logic [PW-1:0]   pitch;
  } timing_t;

  typedef struct packed {
    logic [PANW-1:0] pan_x;
    logic [PANW-1:0] pan_y;
    logic [AW-1:0]   base;
  } origin_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [RAW-1:0] wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           frame_end_i,
  input  logic           vblank_start_i,
  output logic           en_o,
  output timing_t        act_o,
  output timing_t        act_nx_o,
  output origin_t        org_nx_o
);
  timing_t sh_q, act_q;
  origin_t sh_org_q, act_org_q;
  logic    en_q;
  logic    unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[7:1], wr_data_i[15:12], wr_data_i[31:28],
                            wr_data_i[22], wr_data_i[31:24], wr_data_i[15:10],
                            wr_data_i[31:26]};

  assign act_nx_o = (!en_q || frame_end_i) ? sh_q : act_q;
  assign org_nx_o = (!en_q || vblank_start_i) ? sh_org_q : act_org_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      sh_q     <= '0;
      sh_org_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADR_CTRL: begin
          en_q        <= wr_data_i[0];
          sh_q.bpp_sh <= wr_data_i[FMT_LSB +: BPPW];
        end
        ADR_HTD: begin
          sh_q.htot  <= wr_data_i[0 +: HCHW];
          sh_q.hdisp <= wr_data_i[HI_LSB +: HCHW];
        end
        ADR_HSYNC: begin
          sh_q.hs_start <= wr_data_i[0 +: HCW];
          sh_q.hs_wid   <= wr_data_i[HI_LSB +: HSWW];
          sh_q.hs_low   <= wr_data_i[POL_BIT];
        end
        ADR_VTD: begin
          sh_q.vtot  <= wr_data_i[0 +: VLW];
          sh_q.vdisp <= wr_data_i[HI_LSB +: VLW];
        end
        ADR_VSYNC: begin
          sh_q.vs_start <= wr_data_i[0 +: VLW];
          sh_q.vs_wid   <= wr_data_i[HI_LSB +: VSWW];
          sh_q.vs_low   <= wr_data_i[POL_BIT];
        end
        ADR_PITCH: sh_q.pitch <= wr_data_i[0 +: PW];
        ADR_PAN: begin
          sh_org_q.pan_x <= wr_data_i[0 +: PANW];
          sh_org_q.pan_y <= wr_data_i[HI_LSB +: PANW];
        end
        default: sh_org_q.base <= wr_data_i[0 +: AW];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      act_org_q <= '0;
    end else begin
      act_q     <= act_nx_o;
      act_org_q <= org_nx_o;
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
endmodule

// File: rtl/crtc_sync_win.sv
module crtc_sync_win #(
  parameter int W = 12
) (
  input  logic         en_i,
  input  logic [W-1:0] pos_i,
  input  logic [W:0]   first_i,
  input  logic [W:0]   stop_i,
  input  logic         low_i,
  output logic         sync_o
);
  logic hit;
  assign hit    = ({1'b0, pos_i} >= first_i) && ({1'b0, pos_i} < stop_i);
  assign sync_o = low_i ^ (en_i & hit);
endmodule

// File: rtl/crtc_scan_cnt.sv
module crtc_scan_cnt
  import crtc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  timing_t        act_i,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VLW-1:0] v_cnt_o,
  output logic           de_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           line_end_o,
  output logic           frame_end_o,
  output logic           vblank_start_o,
  output logic           disp_line_o
);
  logic [HCW-1:0] h_q, h_max, h_de_last;
  logic [VLW-1:0] v_q;
  logic [HCW:0]   hs_first, hs_stop;
  logic [VLW:0]   vs_first, vs_stop;

  assign h_max     = {act_i.htot, 3'b111};
  assign h_de_last = {act_i.hdisp, 3'b111};

  assign line_end_o     = en_i && (h_q == h_max);
  assign frame_end_o    = line_end_o && (v_q == act_i.vtot);
  assign vblank_start_o = line_end_o && (v_q == act_i.vdisp);
  assign disp_line_o    = v_q <= act_i.vdisp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!en_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end_o) begin
      h_q <= '0;
      v_q <= frame_end_o ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign hs_first = (HCW+1)'(act_i.hs_start);
  assign hs_stop  = hs_first + (HCW+1)'({act_i.hs_wid, 3'b000});
  assign vs_first = (VLW+1)'(act_i.vs_start) + 1'b1;
  assign vs_stop  = vs_first + (VLW+1)'(act_i.vs_wid);

  crtc_sync_win #(.W(HCW)) u_hsync (
    .en_i(en_i), .pos_i(h_q), .first_i(hs_first), .stop_i(hs_stop),
    .low_i(act_i.hs_low), .sync_o(hsync_o)
  );

  crtc_sync_win #(.W(VLW)) u_vsync (
    .en_i(en_i), .pos_i(v_q), .first_i(vs_first), .stop_i(vs_stop),
    .low_i(act_i.vs_low), .sync_o(vsync_o)
  );

  assign de_o    = en_i && (h_q <= h_de_last) && disp_line_o;
  assign h_cnt_o = h_q;
  assign v_cnt_o = v_q;
endmodule

// File: rtl/crtc_line_addr.sv
module crtc_line_addr
  import crtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          line_end_i,
  input  logic          frame_end_i,
  input  logic          disp_line_i,
  input  timing_t       act_i,
  input  timing_t       act_nx_i,
  input  origin_t       org_nx_i,
  output logic [AW-1:0] line_addr_o
);
  logic [AW-1:0] step_bytes, nx_pitch_bytes, start_addr, x_bytes, addr_q;

  // pitch units are 8 pixels, so bytes = pitch << (3 + log2 bytes per pixel)
  assign step_bytes     = AW'(act_i.pitch) << (3 + act_i.bpp_sh);
  assign nx_pitch_bytes = AW'(act_nx_i.pitch) << (3 + act_nx_i.bpp_sh);
  assign x_bytes        = AW'({org_nx_i.pan_x[PANW-1:3], 3'b000}) << act_nx_i.bpp_sh;
  assign start_addr     = AW'(org_nx_i.pan_y) * nx_pitch_bytes + x_bytes + org_nx_i.base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        addr_q <= '0;
    else if (!en_i || frame_end_i)      addr_q <= start_addr;
    else if (line_end_i && disp_line_i) addr_q <= addr_q + step_bytes;
  end

  assign line_addr_o = addr_q;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [RAW-1:0] wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VLW-1:0] v_cnt_o,
  output logic           de_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic [AW-1:0]  line_addr_o
);
  logic    en, line_end, frame_end, vblank_start, disp_line;
  timing_t act, act_nx;
  origin_t org_nx;

  crtc_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_end_i(frame_end), .vblank_start_i(vblank_start),
    .en_o(en), .act_o(act), .act_nx_o(act_nx), .org_nx_o(org_nx)
  );

  crtc_scan_cnt u_cnt (
    .clk_i, .rst_ni, .en_i(en), .act_i(act),
    .h_cnt_o, .v_cnt_o, .de_o, .hsync_o, .vsync_o,
    .line_end_o(line_end), .frame_end_o(frame_end),
    .vblank_start_o(vblank_start), .disp_line_o(disp_line)
  );

  crtc_line_addr u_addr (
    .clk_i, .rst_ni, .en_i(en), .line_end_i(line_end), .frame_end_i(frame_end),
    .disp_line_i(disp_line), .act_i(act), .act_nx_i(act_nx), .org_nx_i(org_nx),
    .line_addr_o
  );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           hs_low_i,
  input logic           vs_low_i,
  input logic [HCW-1:0] h_cnt_i,
  input logic [VLW-1:0] v_cnt_i,
  input logic           de_i,
  input logic           hsync_i,
  input logic           vsync_i,
  input logic [AW-1:0]  line_addr_i
);
  a_r2_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!de_i && hsync_i == hs_low_i && vsync_i == vs_low_i));

  a_r2_counters_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (h_cnt_i == '0 && v_cnt_i == '0));

  a_r3_pixel_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && h_cnt_i != '0) |-> (h_cnt_i == $past(h_cnt_i) + 1'b1));

  a_r4_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && h_cnt_i == '0 && v_cnt_i != '0) |-> (v_cnt_i == $past(v_cnt_i) + 1'b1));

  a_r4_line_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && h_cnt_i != '0) |-> $stable(v_cnt_i));

  a_r7_vsync_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(vsync_i)) |-> (h_cnt_i == '0));

  a_r9_addr_steady_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && h_cnt_i != '0) |-> $stable(line_addr_i));
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
  .hs_low_i(act.hs_low), .vs_low_i(act.vs_low),
  .h_cnt_i(h_cnt_o), .v_cnt_i(v_cnt_o), .de_i(de_o),
  .hsync_i(hsync_o), .vsync_i(vsync_o), .line_addr_i(line_addr_o)
);

// File: tb/crtc_timing_gen_tb_top.sv
module crtc_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] h_cnt, v_cnt;
  logic        de, hsync, vsync;
  logic [31:0] line_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crtc_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt), .de_o(de),
    .hsync_o(hsync), .vsync_o(vsync), .line_addr_o(line_addr)
  );

  typedef struct {
    int unsigned fmt, ht, hd, hs, hw, hp, vt, vd, vs, vw, vp, pitch;
  } tcfg_t;
  typedef struct {
    int unsigned px, py, base;
  } ocfg_t;

  // reference model state
  bit          m_en;
  tcfg_t       s_t, a_t;
  ocfg_t       s_o, a_o;
  int unsigned m_h, m_v, m_addr;

  function automatic int unsigned pbytes(tcfg_t t);
    return t.pitch * 8 * (1 << t.fmt);
  endfunction

  function automatic int unsigned start_of(tcfg_t t, ocfg_t o);
    return o.py * pbytes(t) + (o.px & 32'hfff8) * (1 << t.fmt) + o.base;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (h=%0d v=%0d)", tag, act, exp, m_h, m_v);
    end
  endtask

  task automatic check_outputs();
    int unsigned hmax = (a_t.ht + 1) * 8 - 1;
    bit hs_win = (m_h >= a_t.hs) && (m_h < a_t.hs + a_t.hw * 8);
    bit vs_win = (m_v >= a_t.vs + 1) && (m_v < a_t.vs + 1 + a_t.vw);
    bit e_de   = m_en && (m_h <= a_t.hd * 8 + 7) && (m_v <= a_t.vd);
    if (hmax == 0) hmax = 0;
    chk(m_en ? "R3 R4 R11 counters" : "R2 counters held", {h_cnt, v_cnt}, {m_h[11:0], m_v[11:0]});
    chk(m_en ? "R5 R11 de" : "R2 de idle", 32'(de), 32'(e_de));
    chk(m_en ? "R6 hsync" : "R2 hsync idle", 32'(hsync), 32'(a_t.hp[0] ^ (m_en & hs_win)));
    chk(m_en ? "R7 vsync" : "R2 vsync idle", 32'(vsync), 32'(a_t.vp[0] ^ (m_en & vs_win)));
    chk("R8 R9 R10 line_addr", line_addr, m_addr);
  endtask

  task automatic advance_model(input bit w, input logic [2:0] a, input logic [31:0] d);
    int unsigned hmax = (a_t.ht + 1) * 8 - 1;
    bit le = m_en && (m_h == hmax);
    bit fe = le && (m_v == a_t.vt);
    bit vb = le && (m_v == a_t.vd);
    tcfg_t tn = (!m_en || fe) ? s_t : a_t;
    ocfg_t on = (!m_en || vb) ? s_o : a_o;
    if (!m_en || fe) m_addr = start_of(tn, on);
    else if (le && m_v <= a_t.vd) m_addr = m_addr + pbytes(a_t);
    if (!m_en) begin m_h = 0; m_v = 0; end
    else if (le) begin m_h = 0; m_v = fe ? 0 : m_v + 1; end
    else m_h = m_h + 1;
    a_t = tn;
    a_o = on;
    if (w) begin
      case (a)
        3'd0: begin m_en = d[0]; s_t.fmt = d[9:8]; end
        3'd1: begin s_t.ht = d[8:0]; s_t.hd = d[24:16]; end
        3'd2: begin s_t.hs = d[11:0]; s_t.hw = d[21:16]; s_t.hp = d[23]; end
        3'd3: begin s_t.vt = d[11:0]; s_t.vd = d[27:16]; end
        3'd4: begin s_t.vs = d[11:0]; s_t.vw = d[20:16]; s_t.vp = d[23]; end
        3'd5: s_t.pitch = d[9:0];
        3'd6: begin s_o.px = d[15:0]; s_o.py = d[31:16]; end
        default: s_o.base = d;
      endcase
    end
  endtask

  task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d);
    check_outputs();
    wr_en = w; wr_addr = a; wr_data = d;
    advance_model(w, a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
  endtask

  task automatic write_timing(input tcfg_t t, input int gap);
    step(1'b1, 3'd1, t.ht | (t.hd << 16));                   idle(gap);
    step(1'b1, 3'd2, t.hs | (t.hw << 16) | (t.hp << 23));    idle(gap);
    step(1'b1, 3'd3, t.vt | (t.vd << 16));                   idle(gap);
    step(1'b1, 3'd4, t.vs | (t.vw << 16) | (t.vp << 23));    idle(gap);
    step(1'b1, 3'd5, t.pitch | (t.pitch << 16));             idle(gap);
  endtask

  task automatic write_origin(input ocfg_t o);
    step(1'b1, 3'd6, o.px | (o.py << 16));
    step(1'b1, 3'd7, o.base);
  endtask

  function automatic tcfg_t rand_tcfg();
    tcfg_t t;
    t.fmt   = $urandom_range(0, 3);
    t.ht    = $urandom_range(3, 8);
    t.hd    = $urandom_range(1, t.ht - 1);
    t.hs    = $urandom_range(0, (t.ht + 1) * 8 - 1);
    t.hw    = $urandom_range(1, 3);
    t.hp    = $urandom_range(0, 1);
    t.vt    = $urandom_range(4, 12);
    t.vd    = $urandom_range(1, t.vt - 1);
    t.vs    = $urandom_range(0, t.vt - 1);
    t.vw    = $urandom_range(1, 3);
    t.vp    = $urandom_range(0, 1);
    t.pitch = $urandom_range(1, 1023);
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tcfg_t t;
    ocfg_t o;
    int unsigned seed;
    seed = $urandom(32'h1c0de);
    m_en = 0; s_t = '{default: 0}; a_t = '{default: 0};
    s_o = '{default: 0}; a_o = '{default: 0};
    m_h = 0; m_v = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    chk("R1 reset h/v", {h_cnt, v_cnt}, 24'd0);
    chk("R1 reset de/sync", {29'd0, de, hsync, vsync}, 32'd0);
    chk("R1 reset line_addr", line_addr, 32'd0);

    // directed configuration, fmt code 1 (2 bytes/pixel)
    t = '{fmt:1, ht:5, hd:3, hs:37, hw:1, hp:0, vt:7, vd:4, vs:5, vw:1, vp:1, pitch:4};
    o = '{px:13, py:2, base:32'h1000};
    write_timing(t, 0);
    write_origin(o);
    idle(2);
    step(1'b1, 3'd0, 32'h0000_0101);
    idle(48 * 8 * 2 + 10);

    // R10: pan write early in frame stays hidden; R11: timing change mid-frame
    o = '{px:24, py:1, base:32'h2000};
    write_origin(o);
    t.hd = 2; t.vt = 9; t.hs = 3; t.hp = 1;
    write_timing(t, 5);
    idle(48 * 10 * 3);

    // R2: disable mid-frame, ignored control bits [11:10], re-enable
    idle(100);
    step(1'b1, 3'd0, 32'h0000_0c00);
    idle(40);
    step(1'b1, 3'd0, 32'h0000_0e01);
    idle(48 * 10 * 2);

    // vdisp reaching vtot: both copy points fall together
    t.vd = t.vt; t.pitch = 1023; t.fmt = 3;
    write_timing(t, 0);
    step(1'b1, 3'd0, 32'h0000_0301);
    idle(48 * 10 * 3);

    // constrained random configurations written while running
    for (int k = 0; k < 10; k++) begin
      t = rand_tcfg();
      o.px = $urandom_range(0, 65535);
      o.py = $urandom_range(0, 65535);
      o.base = $urandom;
      write_timing(t, $urandom_range(0, 40));
      idle($urandom_range(0, 300));
      write_origin(o);
      if (k == 4) begin
        step(1'b1, 3'd0, 32'h0);
        idle($urandom_range(1, 20));
      end
      step(1'b1, 3'd0, (t.fmt << 8) | ($urandom_range(0, 3) << 10) | 1);
      idle(72 * 13 * 3);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule